// File: doc/BRIEF.md
# Packed-Lane SIMD Integer ALU

This block is the integer execution stage for one 128-bit vector. It takes three vector source operands, an 18-bit raw immediate and a 4-bit operation code. It produces one vector result through a register, together with a valid strobe, on the clock edge after an operation is presented. Most operations treat the vector as four independent 32-bit lanes. The halfword add-immediate treats it as eight independent 16-bit lanes. No carry or borrow ever crosses a lane boundary.

The operation set covers the following groups:
- Lane add, and a reversed subtract that computes the second operand minus the first.
- Bitwise AND, OR and OR-immediate.
- Unsigned greater-than and equality compares. These produce all-ones or all-zero lane masks and come in register and immediate forms.
- Add-immediate on 32-bit and on 16-bit lanes.
- Two immediate broadcasts, one sign-extended and one zero-extended.
- A three-operand bitwise select.

An operation code outside the defined set does not update the result register. Instead it raises an illegal-operation flag for one cycle. Lane k of a vector occupies bits [32k+31:32k] (or [16k+15:16k] for halfword lanes).

Top module: `simd_lane_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `res_valid`, `illegal_op` and `res_data` are all zero after that edge.
- R2: An accepted legal operation (`in_valid` high, `op_code` 0..13) drives `res_valid` high and `res_data` to its result after the next edge. With `in_valid` low, `res_valid` and `illegal_op` go low and `res_data` keeps its value.
- R3: Code 0 adds each 32-bit lane of `src_a` to the same lane of `src_b`, modulo 2^32, with no carry between lanes.
- R4: Code 1 gives, per 32-bit lane, `src_b` minus `src_a` modulo 2^32 (computed as B plus inverted A plus one).
- R5: Code 2 gives `src_a & src_b`; code 3 gives `src_a | src_b`.
- R6: Code 4 sets a 32-bit lane to 0xFFFFFFFF when the `src_a` lane is unsigned-greater than the `src_b` lane, else 0. Code 5 does the same for equality.
- R7: Code 6 adds, and code 8 ORs, the value `imm_raw[9:0]` sign-extended to 32 bits into every 32-bit lane of `src_a`.
- R8: Code 7 adds `imm_raw[9:0]`, sign-extended to 16 bits, to each of the eight 16-bit lanes of `src_a` modulo 2^16, with no carry between lanes.
- R9: Codes 9 (greater-than) and 10 (equal) compare each 32-bit lane of `src_a`, unsigned, against `imm_raw[9:0]` sign-extended to 32 bits. Each produces a lane mask as in R6.
- R10: Code 11 broadcasts `imm_raw[15:0]` sign-extended to 32 bits into all four lanes. Code 12 broadcasts `imm_raw[17:0]` zero-extended to 32 bits into all four lanes.
- R11: Code 13 takes each result bit from `src_b` where `src_c` is 1 and from `src_a` where `src_c` is 0.
- R12: An accepted code 14 or 15 raises `illegal_op` for one cycle, keeps `res_valid` low and leaves `res_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_code | input | 4 | Operation select (0..13 legal) |
| src_a | input | 128 | First vector operand |
| src_b | input | 128 | Second vector operand |
| src_c | input | 128 | Select mask operand |
| imm_raw | input | 18 | Raw immediate field |
| res_valid | output | 1 | Registered result strobe |
| res_data | output | 128 | Registered vector result |
| illegal_op | output | 1 | Registered undefined-code flag |

## Verification
On every cycle, the in-RTL assertions check the timing contract:
- Reset clearing.
- A valid strobe following each legal acceptance.
- The result holding through idle cycles and undefined codes.
- The all-ones-or-zero shape of every compare result.

The arithmetic values themselves can only be shown by the bench's reference model across its scenarios. These values include lane isolation of carries and borrows, reversed subtract order, sign versus zero extension of each immediate form, and the unsigned ordering of compares on lanes with the top bit set.

// File: rtl/simd_alu_pkg.sv
`timescale 1ns/1ps
package simd_alu_pkg;
  localparam int WORD_W  = 32;
  localparam int HALF_W  = 16;
  localparam int OP_W    = 4;
  localparam int IMMS_W  = 10;
  localparam int IMMB_W  = 16;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'd0,
    OP_SUBR  = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_CGTU  = 4'd4,
    OP_CEQ   = 4'd5,
    OP_ADDI  = 4'd6,
    OP_ADDHI = 4'd7,
    OP_ORI   = 4'd8,
    OP_CGTUI = 4'd9,
    OP_CEQI  = 4'd10,
    OP_LDS16 = 4'd11,
    OP_LDZ18 = 4'd12,
    OP_SEL   = 4'd13
  } op_e;

  typedef enum logic [1:0] {UNIT_ARITH, UNIT_CMP, UNIT_LOGIC} unit_e;
  typedef enum logic [1:0] {AR_ADD, AR_SUBR, AR_ADDI, AR_ADDHI} arith_e;
  typedef enum logic [2:0] {LG_AND, LG_OR, LG_ORI, LG_BC16, LG_BC18, LG_SEL} logic_e;

  typedef struct packed {
    logic   legal;
    unit_e  unit;
    arith_e ar;
    logic_e lg;
    logic   cmp_eq;
    logic   cmp_imm;
  } ctrl_t;
endpackage

// File: rtl/simd_op_decode.sv
`timescale 1ns/1ps
module simd_op_decode
  import simd_alu_pkg::*;
(
  input  logic [OP_W-1:0] op_code,
  output ctrl_t           ctrl
);
  always_comb begin
    ctrl         = '0;
    ctrl.legal   = 1'b1;
    ctrl.unit    = UNIT_ARITH;
    ctrl.ar      = AR_ADD;
    ctrl.lg      = LG_AND;
    unique case (op_code)
      OP_ADD:   ctrl.ar = AR_ADD;
      OP_SUBR:  ctrl.ar = AR_SUBR;
      OP_ADDI:  ctrl.ar = AR_ADDI;
      OP_ADDHI: ctrl.ar = AR_ADDHI;
      OP_AND:   begin ctrl.unit = UNIT_LOGIC; ctrl.lg = LG_AND;  end
      OP_OR:    begin ctrl.unit = UNIT_LOGIC; ctrl.lg = LG_OR;   end
      OP_ORI:   begin ctrl.unit = UNIT_LOGIC; ctrl.lg = LG_ORI;  end
      OP_LDS16: begin ctrl.unit = UNIT_LOGIC; ctrl.lg = LG_BC16; end
      OP_LDZ18: begin ctrl.unit = UNIT_LOGIC; ctrl.lg = LG_BC18; end
      OP_SEL:   begin ctrl.unit = UNIT_LOGIC; ctrl.lg = LG_SEL;  end
      OP_CGTU:  begin ctrl.unit = UNIT_CMP; end
      OP_CEQ:   begin ctrl.unit = UNIT_CMP; ctrl.cmp_eq = 1'b1; end
      OP_CGTUI: begin ctrl.unit = UNIT_CMP; ctrl.cmp_imm = 1'b1; end
      OP_CEQI:  begin ctrl.unit = UNIT_CMP; ctrl.cmp_imm = 1'b1; ctrl.cmp_eq = 1'b1; end
      default:  ctrl.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/simd_imm_extend.sv
`timescale 1ns/1ps
module simd_imm_extend
  import simd_alu_pkg::*;
#(
  parameter int IMM_W = 18
) (
  input  logic [IMM_W-1:0]  imm_raw,
  output logic [WORD_W-1:0] imm_s10_w,
  output logic [HALF_W-1:0] imm_s10_h,
  output logic [WORD_W-1:0] imm_s16_w,
  output logic [WORD_W-1:0] imm_zx_w
);
  localparam int PAD_SW = WORD_W - IMMS_W;
  localparam int PAD_SH = HALF_W - IMMS_W;
  localparam int PAD_BW = WORD_W - IMMB_W;
  localparam int PAD_ZW = WORD_W - IMM_W;

  assign imm_s10_w = {{PAD_SW{imm_raw[IMMS_W-1]}}, imm_raw[IMMS_W-1:0]};
  assign imm_s10_h = {{PAD_SH{imm_raw[IMMS_W-1]}}, imm_raw[IMMS_W-1:0]};
  assign imm_s16_w = {{PAD_BW{imm_raw[IMMB_W-1]}}, imm_raw[IMMB_W-1:0]};
  assign imm_zx_w  = {{PAD_ZW{1'b0}}, imm_raw};
endmodule

// File: rtl/simd_lane_arith.sv
`timescale 1ns/1ps
module simd_lane_arith
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [WORD_W-1:0] imm_w,
  input  logic [HALF_W-1:0] imm_h,
  input  arith_e            mode,
  output logic [DATA_W-1:0] res
);
  localparam int NUM_W = DATA_W / WORD_W;
  localparam int NUM_H = DATA_W / HALF_W;

  logic [DATA_W-1:0] word_res;
  logic [DATA_W-1:0] half_res;

  genvar gw;
  generate
    for (gw = 0; gw < NUM_W; gw++) begin : g_word
      logic [WORD_W-1:0] lane_a, lane_b, add_x, add_y;
      logic              add_cin;
      assign lane_a = opa[gw*WORD_W +: WORD_W];
      assign lane_b = opb[gw*WORD_W +: WORD_W];
      always_comb begin
        unique case (mode)
          AR_SUBR: begin add_x = lane_b; add_y = ~lane_a; add_cin = 1'b1; end
          AR_ADDI: begin add_x = lane_a; add_y = imm_w;   add_cin = 1'b0; end
          default: begin add_x = lane_a; add_y = lane_b;  add_cin = 1'b0; end
        endcase
      end
      assign word_res[gw*WORD_W +: WORD_W] = add_x + add_y + {{(WORD_W-1){1'b0}}, add_cin};
    end
    for (gw = 0; gw < NUM_H; gw++) begin : g_half
      assign half_res[gw*HALF_W +: HALF_W] = opa[gw*HALF_W +: HALF_W] + imm_h;
    end
  endgenerate

  assign res = (mode == AR_ADDHI) ? half_res : word_res;
endmodule

// File: rtl/simd_lane_compare.sv
`timescale 1ns/1ps
module simd_lane_compare
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [WORD_W-1:0] imm_w,
  input  logic              use_imm,
  input  logic              eq_mode,
  output logic [DATA_W-1:0] res
);
  localparam int NUM_W = DATA_W / WORD_W;

  genvar gl;
  generate
    for (gl = 0; gl < NUM_W; gl++) begin : g_lane
      logic [WORD_W-1:0] lhs, rhs;
      logic              hit;
      assign lhs = opa[gl*WORD_W +: WORD_W];
      assign rhs = use_imm ? imm_w : opb[gl*WORD_W +: WORD_W];
      assign hit = eq_mode ? (lhs == rhs) : (lhs > rhs);
      assign res[gl*WORD_W +: WORD_W] = {WORD_W{hit}};
    end
  endgenerate
endmodule

// File: rtl/simd_logic_unit.sv
`timescale 1ns/1ps
module simd_logic_unit
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] opc,
  input  logic [WORD_W-1:0] imm_s10,
  input  logic [WORD_W-1:0] imm_s16,
  input  logic [WORD_W-1:0] imm_zx,
  input  logic_e            mode,
  output logic [DATA_W-1:0] res
);
  localparam int NUM_W = DATA_W / WORD_W;

  always_comb begin
    unique case (mode)
      LG_AND:  res = opa & opb;
      LG_OR:   res = opa | opb;
      LG_ORI:  res = opa | {NUM_W{imm_s10}};
      LG_BC16: res = {NUM_W{imm_s16}};
      LG_BC18: res = {NUM_W{imm_zx}};
      LG_SEL:  res = (opc & opb) | (~opc & opa);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/simd_lane_alu.sv
`timescale 1ns/1ps
module simd_lane_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int IMM_W  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] src_c,
  input  logic [IMM_W-1:0]  imm_raw,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              illegal_op
);
  localparam int NUM_W = DATA_W / WORD_W;
  localparam logic [OP_W-1:0] LAST_LEGAL = OP_SEL;

  ctrl_t             ctrl;
  logic [WORD_W-1:0] imm_s10_w, imm_s16_w, imm_zx_w;
  logic [HALF_W-1:0] imm_s10_h;
  logic [DATA_W-1:0] ar_y, cmp_y, lg_y, next_y;
  logic              take;

  simd_op_decode u_dec (.op_code(op_code), .ctrl(ctrl));

  simd_imm_extend #(.IMM_W(IMM_W)) u_imm (
    .imm_raw(imm_raw), .imm_s10_w(imm_s10_w), .imm_s10_h(imm_s10_h),
    .imm_s16_w(imm_s16_w), .imm_zx_w(imm_zx_w)
  );

  simd_lane_arith #(.DATA_W(DATA_W)) u_ar (
    .opa(src_a), .opb(src_b), .imm_w(imm_s10_w), .imm_h(imm_s10_h),
    .mode(ctrl.ar), .res(ar_y)
  );

  simd_lane_compare #(.DATA_W(DATA_W)) u_cmp (
    .opa(src_a), .opb(src_b), .imm_w(imm_s10_w), .use_imm(ctrl.cmp_imm),
    .eq_mode(ctrl.cmp_eq), .res(cmp_y)
  );

  simd_logic_unit #(.DATA_W(DATA_W)) u_lg (
    .opa(src_a), .opb(src_b), .opc(src_c), .imm_s10(imm_s10_w),
    .imm_s16(imm_s16_w), .imm_zx(imm_zx_w), .mode(ctrl.lg), .res(lg_y)
  );

  always_comb begin
    unique case (ctrl.unit)
      UNIT_CMP:   next_y = cmp_y;
      UNIT_LOGIC: next_y = lg_y;
      default:    next_y = ar_y;
    endcase
  end

  assign take = in_valid & ctrl.legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      illegal_op <= 1'b0;
      res_data   <= '0;
    end else begin
      res_valid  <= take;
      illegal_op <= in_valid & ~ctrl.legal;
      if (take) res_data <= next_y;
    end
  end

  function automatic logic lanes_are_masks(input logic [DATA_W-1:0] v);
    logic good;
    good = 1'b1;
    for (int k = 0; k < NUM_W; k++) begin
      if (!((v[k*WORD_W +: WORD_W] == '0) || (&v[k*WORD_W +: WORD_W]))) good = 1'b0;
    end
    return good;
  endfunction

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!res_valid && !illegal_op && res_data == '0)); // R1
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) (in_valid && op_code <= LAST_LEGAL) |=> (res_valid && !illegal_op)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!res_valid && !illegal_op && $stable(res_data))); // R2
  AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (rst) (in_valid && op_code > LAST_LEGAL) |=> (illegal_op && !res_valid && $stable(res_data))); // R12
  AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (rst) (in_valid && (op_code == OP_CGTU || op_code == OP_CEQ || op_code == OP_CGTUI || op_code == OP_CEQI)) |=> lanes_are_masks(res_data)); // R6
endmodule

// File: tb/simd_lane_alu_tb.sv
`timescale 1ns/1ps
module simd_lane_alu_tb_top;
  localparam real CLK_PERIOD = 8.0;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [3:0]   op_code = '0;
  logic [127:0] src_a = '0, src_b = '0, src_c = '0;
  logic [17:0]  imm_raw = '0;
  logic         res_valid, illegal_op;
  logic [127:0] res_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  logic         exp_valid = 1'b0, exp_ill = 1'b0;
  logic [127:0] exp_data = '0;
  string        exp_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_lane_alu dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .src_c(src_c), .imm_raw(imm_raw),
    .res_valid(res_valid), .res_data(res_data), .illegal_op(illegal_op)
  );

  function automatic string tag_of(input int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2, 3: return "R5";
      4, 5: return "R6";
      6, 8: return "R7";
      7: return "R8";
      9, 10: return "R9";
      11, 12: return "R10";
      13: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [127:0] ref_calc(input int op, input logic [127:0] a, b, c,
                                             input logic [17:0] imm);
    logic [127:0] r;
    logic [31:0]  s10, s16, z18;
    int unsigned  wa, wb;
    s10 = 32'(signed'(imm[9:0]));
    s16 = 32'(signed'(imm[15:0]));
    z18 = {14'd0, imm};
    r = '0;
    for (int k = 0; k < 4; k++) begin
      wa = a[32*k +: 32];
      wb = b[32*k +: 32];
      case (op)
        0:  r[32*k +: 32] = wa + wb;
        1:  r[32*k +: 32] = wb - wa;
        4:  r[32*k +: 32] = (wa > wb) ? 32'hFFFF_FFFF : 32'h0;
        5:  r[32*k +: 32] = (wa == wb) ? 32'hFFFF_FFFF : 32'h0;
        6:  r[32*k +: 32] = wa + s10;
        8:  r[32*k +: 32] = wa | s10;
        9:  r[32*k +: 32] = (wa > s10) ? 32'hFFFF_FFFF : 32'h0;
        10: r[32*k +: 32] = (wa == s10) ? 32'hFFFF_FFFF : 32'h0;
        11: r[32*k +: 32] = s16;
        12: r[32*k +: 32] = z18;
        default: ;
      endcase
    end
    if (op == 7) for (int h = 0; h < 8; h++) r[16*h +: 16] = a[16*h +: 16] + s10[15:0];
    if (op == 2) r = a & b;
    if (op == 3) r = a | b;
    if (op == 13) for (int i = 0; i < 128; i++) r[i] = c[i] ? b[i] : a[i];
    return r;
  endfunction

  // Reference model, advanced on each clock edge.
  always @(posedge clk) begin
    if (rst) begin
      exp_valid = 1'b0; exp_ill = 1'b0; exp_data = '0; exp_tag = "R1";
    end else if (!in_valid) begin
      exp_valid = 1'b0; exp_ill = 1'b0; exp_tag = "R2";
    end else if (op_code > 4'd13) begin
      exp_valid = 1'b0; exp_ill = 1'b1; exp_tag = "R12";
    end else begin
      exp_valid = 1'b1; exp_ill = 1'b0;
      exp_data = ref_calc(int'(op_code), src_a, src_b, src_c, imm_raw);
      exp_tag = tag_of(int'(op_code));
    end
  end

  // Compare every clock, away from the edge.
  always @(posedge clk) begin
    #2;
    if (!finished) begin
      n_checks++;
      if (res_valid !== exp_valid) begin
        n_fails++;
        $display("FAIL %s res_valid actual=%b expected=%b", exp_tag, res_valid, exp_valid);
      end
      n_checks++;
      if (illegal_op !== exp_ill) begin
        n_fails++;
        $display("FAIL %s illegal_op actual=%b expected=%b", exp_tag, illegal_op, exp_ill);
      end
      n_checks++;
      if (res_data !== exp_data) begin
        n_fails++;
        $display("FAIL %s res_data actual=%h expected=%h", exp_tag, res_data, exp_data);
      end
    end
  end

  task automatic issue(input int op, input logic [127:0] a, b, c, input logic [17:0] imm);
    @(negedge clk);
    in_valid = 1'b1; op_code = 4'(op);
    src_a = a; src_b = b; src_c = c; imm_raw = imm;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    in_valid = 1'b0;
    op_code = 4'($urandom_range(0, 15));
    src_a = {4{$urandom}}; src_b = {4{$urandom}}; imm_raw = 18'($urandom);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero while reset held, checked by the per-clock compare
    rst = 1'b0;
    // R3: carry must not cross lanes
    issue(0, {4{32'hFFFF_FFFF}}, {4{32'h0000_0001}}, '0, '0);
    issue(0, {32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 32'h1234_5678}, {32'h1, 32'h2, 32'h8000_0000, 32'h1111_1111}, '0, '0);
    // R4: reversed subtract with borrow
    issue(1, {4{32'h0000_0001}}, {4{32'h0}}, '0, '0);
    issue(1, {32'h5, 32'h0, 32'hFFFF_FFFF, 32'h10}, {32'h9, 32'h7, 32'h0, 32'h10}, '0, '0);
    // R5
    issue(2, rnd128(), rnd128(), '0, '0);
    issue(3, rnd128(), rnd128(), '0, '0);
    // R6: unsigned order with top bit set, and equality
    issue(4, {32'h8000_0000, 32'h1, 32'h5, 32'hFFFF_FFFF}, {32'h7FFF_FFFF, 32'h2, 32'h5, 32'h0}, '0, '0);
    issue(5, {32'h8000_0000, 32'h1, 32'h5, 32'hFFFF_FFFF}, {32'h7FFF_FFFF, 32'h2, 32'h5, 32'hFFFF_FFFF}, '0, '0);
    // R7: negative immediate sign extension
    issue(6, {4{32'h0000_0010}}, '0, '0, 18'h003FF);
    issue(8, {4{32'h0000_0000}}, '0, '0, 18'h00200);
    // R8: halfword lanes, wrap inside a lane
    issue(7, {8{16'hFFFF}}, '0, '0, 18'h00001);
    issue(7, {8{16'h0100}}, '0, '0, 18'h00201);
    // R9: compare against extended immediate
    issue(9, {32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h0, 32'h8000_0000}, '0, '0, 18'h003FE);
    issue(10, {32'hFFFF_FFFF, 32'h3FF, 32'h0, 32'hFFFF_FFFF}, '0, '0, 18'h003FF);
    // R10
    issue(11, '0, '0, '0, 18'h08000);
    issue(12, '0, '0, '0, 18'h3FFFF);
    // R11
    issue(13, {4{32'h0000_FFFF}}, {4{32'hFFFF_0000}}, {4{32'hF0F0_F0F0}}, '0);
    // R12: undefined codes hold the result
    issue(14, rnd128(), rnd128(), '0, '0);
    issue(15, rnd128(), rnd128(), '0, '0);
    // R2: idle cycles hold the result
    idle_cycle();
    idle_cycle();
    // Mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 5) == 0) idle_cycle();
      else issue(int'($urandom_range(0, 15)), rnd128(), rnd128(), rnd128(), 18'($urandom));
    end
    // R1: reset in mid-stream
    issue(0, rnd128(), rnd128(), '0, '0);
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    repeat (3) idle_cycle();
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule